// File: doc/BRIEF.md
# Instruction Fetch Loop Buffer

This block sits beside the instruction fetch stage. It keeps the instruction words fetched most recently from one aligned address region, in their fetch positions. When the fetch stage presents a branch target, the block answers in the same cycle. It reports a hit and returns the stored word if the target lies inside the region the buffer covers and that word has already been filled. Otherwise it reports a miss, and the fetch stage reads memory instead.

Words returned from memory are written back through the fill port. After a loop body that fits inside one region has been fetched once, every later iteration is served from the buffer without any memory traffic.

The buffer region is 2^IDX_W bytes, which is 256 bytes by default. The low IDX_W address bits select a word inside the region. The remaining upper bits are compared with the stored region tag. A fill into a different region drops every valid word and moves the buffer onto the new region. A flush input empties the buffer, for example after code has been rewritten or the context has changed.

Top module: `fetch_loop_buffer`

## Requirements
- R1: After reset no word is valid, so any lookup reports hit=0 and miss=1.
- R2: A lookup hits when lookup_addr[ADDR_W-1:IDX_W] equals the stored region tag and the addressed word is valid. On a hit, rd_data is the last data filled at that word.
- R3: miss is the inverse of hit while lookup_valid is high. When lookup_valid is low, hit, miss and rd_data are all zero.
- R4: A fill whose upper bits match the stored region tag marks only the addressed word valid. Words filled earlier in that region stay valid.
- R5: A fill into a different region invalidates every word, stores the new region tag and marks only the filled word valid.
- R6: A flush invalidates every word. From the next cycle on, lookups miss until fills occur again.
- R7: When flush and fill_valid are high in the same cycle, the flush wins and the fill is discarded.
- R8: A lookup in the same cycle as a fill of the same word sees the state from before the fill. The fill becomes visible from the following cycle.
- R9: Address bits below the word size (bits [1:0] for 32-bit words) are ignored by both lookups and fills.
- R10: Filling a word that is already valid replaces its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate the whole buffer |
| lookup_valid | input | 1 | Branch target lookup request |
| lookup_addr | input | ADDR_W | Branch target byte address |
| hit | output | 1 | Target word is present in the buffer |
| miss | output | 1 | Lookup requested but target not present |
| rd_data | output | DATA_W | Instruction word on a hit, otherwise zero |
| fill_valid | input | 1 | Memory returns a fetched word |
| fill_addr | input | ADDR_W | Byte address of the returned word |
| fill_data | input | DATA_W | Returned instruction word |

## Verification
Two pairs of functions can meet in one cycle. The first pair is a flush together with a fill. The bench raises both in the same cycle and then looks up the word that was being filled as well as a word that was valid before. It expects a miss for both, because the flush is required to win.

The second pair is a lookup together with a fill of the same word. The bench drives both in one cycle and expects a miss in that cycle, then a hit with the new data in the next cycle. A fill that switches to a new region while an old-region word is being looked up is covered as well: the old word must still hit in the fill cycle and must miss after it.

// File: rtl/fetch_loop_buffer.sv
module fetch_loop_buffer #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              lookup_valid,
  input  logic [ADDR_W-1:0] lookup_addr,
  output logic              hit,
  output logic              miss,
  output logic [DATA_W-1:0] rd_data,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [DATA_W-1:0] fill_data
);
  localparam int OFS_W = $clog2(DATA_W / 8);
  localparam int WI_W  = IDX_W - OFS_W;
  localparam int WORDS = 1 << WI_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [DATA_W-1:0] mem [WORDS];
  logic [WORDS-1:0]  vld;
  logic [TAG_W-1:0]  tag_q;

  wire [TAG_W-1:0] lk_tag = lookup_addr[ADDR_W-1:IDX_W];
  wire [WI_W-1:0]  lk_idx = lookup_addr[IDX_W-1:OFS_W];
  wire [TAG_W-1:0] fl_tag = fill_addr[ADDR_W-1:IDX_W];
  wire [WI_W-1:0]  fl_idx = fill_addr[IDX_W-1:OFS_W];
  wire             fill_go = fill_valid && !flush;

  assign hit     = lookup_valid && (lk_tag == tag_q) && vld[lk_idx];
  assign miss    = lookup_valid && !hit;
  assign rd_data = hit ? mem[lk_idx] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld   <= '0;
      tag_q <= '0;
    end else if (flush) begin
      vld <= '0;
    end else if (fill_valid) begin
      if (fl_tag != tag_q) begin
        vld   <= WORDS'(1) << fl_idx;
        tag_q <= fl_tag;
      end else begin
        vld[fl_idx] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_go) mem[fl_idx] <= fill_data;
  end
endmodule

// File: rtl/fetch_loop_buffer_chk.sv
module fetch_loop_buffer_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              lookup_valid,
  input logic [ADDR_W-1:0] lookup_addr,
  input logic              hit,
  input logic              miss,
  input logic [DATA_W-1:0] rd_data,
  input logic              fill_valid,
  input logic [ADDR_W-1:0] fill_addr,
  input logic [DATA_W-1:0] fill_data
);
  localparam int OFS_W = $clog2(DATA_W / 8);

  p_one_answer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_valid |-> (hit != miss));

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup_valid |-> (!hit && !miss && rd_data == '0));

  p_flush_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !hit);

  p_fill_visible_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !flush) |=>
      ((lookup_valid && lookup_addr[ADDR_W-1:OFS_W] == $past(fill_addr[ADDR_W-1:OFS_W]))
        |-> (hit && rd_data == $past(fill_data))));

  p_region_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !flush) |=>
      ((lookup_valid && lookup_addr[ADDR_W-1:IDX_W] != $past(fill_addr[ADDR_W-1:IDX_W]))
        |-> !hit));

  p_empty_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !hit);
endmodule

bind fetch_loop_buffer fetch_loop_buffer_chk #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .lookup_valid(lookup_valid),
  .lookup_addr(lookup_addr), .hit(hit), .miss(miss), .rd_data(rd_data),
  .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data)
);

// File: tb/tb_fetch_loop_buffer.sv
module tb_fetch_loop_buffer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        lookup_valid = 1'b0;
  logic [31:0] lookup_addr = '0;
  logic        hit, miss;
  logic [31:0] rd_data;
  logic        fill_valid = 1'b0;
  logic [31:0] fill_addr = '0;
  logic [31:0] fill_data = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fetch_loop_buffer dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .lookup_valid(lookup_valid),
    .lookup_addr(lookup_addr), .hit(hit), .miss(miss), .rd_data(rd_data),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    fill_valid = 1'b1; fill_addr = a; fill_data = d;
    @(posedge clk); #1;
    fill_valid = 1'b0;
  endtask

  task automatic look(input string req, input logic [31:0] a,
                      input logic eh, input logic [31:0] ed);
    @(negedge clk);
    lookup_valid = 1'b1; lookup_addr = a;
    #1;
    check(req, {hit, miss, rd_data}, {eh, !eh, ed});
    lookup_valid = 1'b0;
  endtask

  task automatic t_reset;
    look("R1 empty after reset", 32'h0000_0000, 1'b0, '0);
    look("R1 empty after reset", 32'h0000_1204, 1'b0, '0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    lookup_valid = 1'b0; lookup_addr = 32'h1200; #1;
    check("R3 idle outputs", {hit, miss, rd_data}, '0);
  endtask

  task automatic t_fill_hit;
    fill(32'h0000_1200, 32'hAAAA_0001);
    fill(32'h0000_1204, 32'hAAAA_0002);
    fill(32'h0000_12FC, 32'hAAAA_003F);
    look("R2 hit word0", 32'h0000_1200, 1'b1, 32'hAAAA_0001);
    look("R4 earlier word kept", 32'h0000_1204, 1'b1, 32'hAAAA_0002);
    look("R2 hit last word", 32'h0000_12FC, 1'b1, 32'hAAAA_003F);
    look("R3 unfilled word misses", 32'h0000_1208, 1'b0, '0);
    look("R2 other region misses", 32'h0000_1300, 1'b0, '0);
    look("R9 byte offset ignored", 32'h0000_1207, 1'b1, 32'hAAAA_0002);
    fill(32'h0000_120B, 32'hAAAA_0003);
    look("R9 fill offset ignored", 32'h0000_1208, 1'b1, 32'hAAAA_0003);
  endtask

  task automatic t_loop;
    for (int it = 0; it < 3; it++)
      for (int w = 0; w < 3; w++)
        look("R2 loop iteration hit", 32'h0000_1200 + 32'(w * 4), 1'b1, 32'hAAAA_0001 + 32'(w));
  endtask

  task automatic t_overwrite;
    fill(32'h0000_1204, 32'hBBBB_0002);
    look("R10 overwrite", 32'h0000_1204, 1'b1, 32'hBBBB_0002);
  endtask

  task automatic t_region;
    fill(32'h0000_5310, 32'hCCCC_0004);
    look("R5 new word hit", 32'h0000_5310, 1'b1, 32'hCCCC_0004);
    look("R5 old region dropped", 32'h0000_1200, 1'b0, '0);
    look("R5 same index old region", 32'h0000_1210, 1'b0, '0);
    look("R5 only filled word valid", 32'h0000_5300, 1'b0, '0);
  endtask

  task automatic t_flush;
    @(negedge clk); flush = 1'b1;
    @(posedge clk); #1; flush = 1'b0;
    look("R6 flushed", 32'h0000_5310, 1'b0, '0);
    fill(32'h0000_5310, 32'hDDDD_0004);
    look("R6 refill after flush", 32'h0000_5310, 1'b1, 32'hDDDD_0004);
  endtask

  task automatic t_flush_fill;
    @(negedge clk);
    flush = 1'b1; fill_valid = 1'b1; fill_addr = 32'h0000_5314; fill_data = 32'hEEEE_0005;
    @(posedge clk); #1;
    flush = 1'b0; fill_valid = 1'b0;
    look("R7 fill dropped", 32'h0000_5314, 1'b0, '0);
    look("R7 older word flushed", 32'h0000_5310, 1'b0, '0);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    fill_valid = 1'b1; fill_addr = 32'h0000_5320; fill_data = 32'hF0F0_0008;
    lookup_valid = 1'b1; lookup_addr = 32'h0000_5320;
    #1;
    check("R8 pre-fill view", {hit, miss}, 2'b01);
    @(posedge clk); #1;
    fill_valid = 1'b0;
    check("R8 post-fill view", {hit, miss, rd_data}, {2'b10, 32'hF0F0_0008});
    fill(32'h0000_5324, 32'hF0F0_0009);
    @(negedge clk);
    fill_valid = 1'b1; fill_addr = 32'h0000_7700; fill_data = 32'h1111_2222;
    lookup_addr = 32'h0000_5324; #1;
    check("R8 old region visible in switch cycle", {hit, rd_data}, {1'b1, 32'hF0F0_0009});
    @(posedge clk); #1;
    fill_valid = 1'b0;
    check("R5 old region gone after switch", {hit, miss}, 2'b01);
    lookup_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_idle();
    t_fill_hit();
    t_loop();
    t_overwrite();
    t_region();
    t_flush();
    t_flush_fill();
    t_same_cycle();
    t_idle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule